// File: doc/BRIEF.md
# Constant-Divisor Reciprocal Divider

This block divides an unsigned 32-bit dividend by a divisor that is fixed when the design is elaborated. It uses no iterative divider. When the divisor is a power of two, the quotient comes from a right shift and the remainder from a bit mask.

Any other divisor works through a reciprocal. At elaboration the block computes a scaled reciprocal constant and a post-shift from the divisor parameter. At run time the dividend is multiplied by that constant to form a 64-bit product, and the high half of the product goes through an add-and-halve correction before the final shift. This makes the quotient exact for every 32-bit dividend. The remainder is then the dividend minus the quotient times the divisor.

The datapath has two pipeline stages. It accepts a new dividend on every cycle and returns results in the order the dividends arrived. A divisor parameter of zero stops elaboration with an error.

Top module: `recipDivTop`

## Requirements
- R1: With a power-of-two divisor 2^k, the quotient equals the dividend shifted right by k bits.
- R2: With a power-of-two divisor 2^k, the remainder equals the dividend ANDed with 2^k-1.
- R3: With any other divisor, the quotient equals the floor of dividend/divisor for every 32-bit dividend, including 0, divisor-1, divisor and 0xFFFFFFFF.
- R4: The remainder equals the dividend minus the quotient times the divisor, and it is always strictly less than the divisor.
- R5: A dividend presented with inValid high on the clock edge at cycle n produces outValid high, with its result, in cycle n+2 only. outValid is low in cycle n+1.
- R6: Dividends presented on consecutive cycles produce results on consecutive cycles, in the same order and with no gaps.
- R7: In a cycle where no result is due, outValid is low and outQuot and outRem keep their previous values.
- R8: While rstN is low, and after reset until the first result, outValid, outQuot and outRem are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Dividend strobe |
| inDividend | input | 32 | Unsigned dividend |
| outValid | output | 1 | Result strobe, two cycles after inValid |
| outQuot | output | 32 | Quotient |
| outRem | output | 32 | Remainder |

## Verification
The bench aims at the dividends where a reciprocal that is too coarse fails: 0xFFFFFFFF and the values on either side of a multiple of the divisor. With a divisor of 7, a constant that skipped the add-and-halve correction would return a quotient one too small near the top of the range, and the remainder would then reach or exceed 7. Back-to-back streams expose a stage-enable or ordering fault, which would show up as results that are duplicated, shifted or lost. A second instance with a divisor of 16 covers the shift-and-mask path, where an off-by-one shift amount or mask width would corrupt every result.

// File: rtl/recipDivPkg.sv
package recipDivPkg;

  localparam int DW = 32;

  typedef struct packed {
    logic loadStage1;
    logic loadStage2;
  } divStrobes_t;

  function automatic bit isPow2(input logic [DW-1:0] d);
    return (d != '0) && ((d & (d - 1'b1)) == '0);
  endfunction

  // smallest l with 2^l >= d
  function automatic int ceilLog2(input logic [DW-1:0] d);
    int r;
    r = DW;
    for (int i = DW; i >= 0; i--) begin
      if ((65'(1) << i) >= 65'(d)) r = i;
    end
    return r;
  endfunction

  // low DW bits of the round-up reciprocal: floor(2^DW*(2^l-d)/d)+1
  function automatic logic [DW-1:0] magicOf(input logic [DW-1:0] d);
    logic [2*DW+1:0] num;
    int l;
    if (d == '0) return '0;
    l = ceilLog2(d);
    num = ((66'(1) << l) - 66'(d)) << DW;
    return DW'(num / 66'(d) + 66'(1));
  endfunction

endpackage

// File: rtl/recipDivCtrl.sv
module recipDivCtrl
  import recipDivPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output divStrobes_t strobes,
  output logic        outValid
);

  logic valid1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid1   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      valid1   <= inValid;
      outValid <= valid1;
    end
  end

  always_comb begin
    strobes.loadStage1 = inValid;
    strobes.loadStage2 = valid1;
  end

endmodule

// File: rtl/recipDivPath.sv
module recipDivPath
  import recipDivPkg::*;
#(
  parameter logic [DW-1:0] DIVISOR = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  divStrobes_t   strobes,
  input  logic [DW-1:0] inDividend,
  output logic [DW-1:0] outQuot,
  output logic [DW-1:0] outRem
);

  localparam bit            POW2    = isPow2(DIVISOR);
  localparam int            SHIFT_L = ceilLog2(DIVISOR);
  localparam logic [DW-1:0] MAGIC   = magicOf(DIVISOR);
  localparam logic [DW-1:0] MASK    = DIVISOR - 1'b1;

  logic [DW-1:0] dividend1;

  generate
    if (POW2) begin : g_shift
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dividend1 <= '0;
          outQuot   <= '0;
          outRem    <= '0;
        end else begin
          if (strobes.loadStage1) dividend1 <= inDividend;
          if (strobes.loadStage2) begin
            outQuot <= dividend1 >> SHIFT_L;
            outRem  <= dividend1 & MASK;
          end
        end
      end
    end else begin : g_recip
      logic [2*DW-1:0] product;
      logic [DW-1:0]   highPart1;
      logic [DW-1:0]   fixedSum;
      logic [DW-1:0]   quotNext;
      logic [DW-1:0]   backMul;

      always_comb begin
        product  = (2*DW)'(inDividend) * (2*DW)'(MAGIC);
        fixedSum = highPart1 + ((dividend1 - highPart1) >> 1);
        quotNext = fixedSum >> (SHIFT_L - 1);
        backMul  = DW'(quotNext * DIVISOR);
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dividend1 <= '0;
          highPart1 <= '0;
          outQuot   <= '0;
          outRem    <= '0;
        end else begin
          if (strobes.loadStage1) begin
            dividend1 <= inDividend;
            highPart1 <= product[2*DW-1:DW];
          end
          if (strobes.loadStage2) begin
            outQuot <= quotNext;
            outRem  <= dividend1 - backMul;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/recipDivTop.sv
module recipDivTop
  import recipDivPkg::*;
#(
  parameter logic [31:0] DIVISOR = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inDividend,
  output logic        outValid,
  output logic [31:0] outQuot,
  output logic [31:0] outRem
);

  generate
    if (DIVISOR == 0) begin : g_badDivisor
      $error("recipDivTop: DIVISOR must be nonzero");
    end
  endgenerate

  divStrobes_t strobes;

  recipDivCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  recipDivPath #(.DIVISOR(DIVISOR)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inDividend (inDividend),
    .outQuot    (outQuot),
    .outRem     (outRem)
  );

endmodule

// File: rtl/recipDivCheck.sv
module recipDivCheck #(
  parameter logic [31:0] DIVISOR = 7
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inDividend,
  input logic        outValid,
  input logic [31:0] outQuot,
  input logic [31:0] outRem
);

  // R4: remainder below divisor (flags a wrong reciprocal)
  a_r4_rem_below: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outRem < DIVISOR));

  // R3 / R4: quotient and remainder recombine to the dividend
  a_r3_recombine: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((64'(outQuot) * 64'(DIVISOR) + 64'(outRem)) == 64'($past(inDividend, 2))));

  // R5: every accepted dividend yields a result two cycles on
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  // R7: no result without a dividend two cycles before
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);

  // R7: outputs hold while no result is due
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outQuot) && $stable(outRem)));

endmodule

bind recipDivTop recipDivCheck #(.DIVISOR(DIVISOR)) u_recipDivCheck (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inDividend (inDividend),
  .outValid   (outValid),
  .outQuot    (outQuot),
  .outRem     (outRem)
);

// File: tb/recipDivTop_bench.sv
module recipDivTop_bench;

  localparam logic [31:0] DIV_A = 32'd7;
  localparam logic [31:0] DIV_B = 32'd16;
  localparam int          NVEC  = 12;
  localparam int          NRAND = 40;

  localparam logic [31:0] VECS [NVEC] = '{
    32'd0, 32'd1, 32'd6, 32'd7, 32'd8, 32'd15, 32'd16, 32'd17,
    32'hFFFFFFFF, 32'hFFFFFFFE, 32'h80000000, 32'h7FFFFFFF
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inDividend = '0;
  logic        vA, vB;
  logic [31:0] qA, rA, qB, rB;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  recipDivTop #(.DIVISOR(DIV_A)) u_recipDivTop (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDividend(inDividend),
    .outValid(vA), .outQuot(qA), .outRem(rA));

  recipDivTop #(.DIVISOR(DIV_B)) u_recipDivTop_pow2 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDividend(inDividend),
    .outValid(vB), .outQuot(qB), .outRem(rB));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // results for dividend n, sampled in the cycle they are due
  task automatic chkResult(input logic [31:0] n);
    chk("R5 valid A", 64'(vA), 64'(1));
    chk("R3 quot /7", 64'(qA), 64'(n / DIV_A));
    chk("R4 rem /7", 64'(rA), 64'(n % DIV_A));
    chk("R5 valid B", 64'(vB), 64'(1));
    chk("R1 quot shift", 64'(qB), 64'(n >> 4));
    chk("R2 rem mask", 64'(rB), 64'(n & 32'hF));
  endtask

  // stream a list back-to-back; result k is due two negedges after it was driven
  task automatic runStream(input logic [31:0] vals [], input int cnt);
    for (int i = 0; i < cnt + 2; i++) begin
      @(negedge clk);
      if (i >= 2) chkResult(vals[i-2]);   // R6 ordered, gap-free
      if (i < cnt) begin
        inValid    = 1'b1;
        inDividend = vals[i];
      end else begin
        inValid    = 1'b0;
        inDividend = 32'hDEADBEEF;
      end
    end
  endtask

  initial begin
    logic [31:0] vals [];
    logic [31:0] lastQ, lastR;

    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 valid in reset", 64'(vA), 64'(0));
    chk("R8 quot in reset", 64'(qA), 64'(0));
    chk("R8 rem in reset", 64'(rA), 64'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 valid after reset", 64'(vA | vB), 64'(0));
    chk("R8 outputs after reset", {qA, rB}, 64'(0));

    // table walk, back to back
    vals = new[NVEC];
    for (int i = 0; i < NVEC; i++) vals[i] = VECS[i];
    runStream(vals, NVEC);

    // R7: idle cycles hold outputs, no valid
    lastQ = qA; lastR = rA;
    @(negedge clk);
    chk("R7 valid idle", 64'(vA), 64'(0));
    chk("R7 quot held", 64'(qA), 64'(lastQ));
    chk("R7 rem held", 64'(rA), 64'(lastR));

    // R5: single isolated dividend, latency exactly two
    @(negedge clk);
    inValid = 1'b1; inDividend = 32'd1000;
    @(negedge clk);
    inValid = 1'b0; inDividend = 32'd5;
    chk("R5 not yet valid", 64'(vA), 64'(0));
    @(negedge clk);
    chkResult(32'd1000);
    @(negedge clk);
    chk("R5 single pulse", 64'(vA), 64'(0));
    chk("R7 quot held after pulse", 64'(qA), 64'(32'd142));

    // corner values around multiples of 7 near the top
    vals = new[6];
    vals[0] = 32'hFFFFFFFC; vals[1] = 32'hFFFFFFFB; vals[2] = 32'hFFFFFFFD;
    vals[3] = 32'd7 * 32'd613566756; vals[4] = vals[3] - 1; vals[5] = vals[3] + 1;
    runStream(vals, 6);

    // random stream
    vals = new[NRAND];
    for (int i = 0; i < NRAND; i++) vals[i] = $urandom;
    runStream(vals, NRAND);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule